// File: doc/BRIEF.md
# Three-State PWM Gate-Drive Sequencer

This block is the digital sequencer for the two gates of a synchronous buck power stage. It takes a PWM command that has already been decoded into low, high or mid-level. It also takes these inputs:
- an active-low stage disable and a supply-good flag;
- an active-low diode-emulation enable and an inductor-current-negative flag;
- two feedback comparators that report when the low-side gate, and the high-side gate measured to the switch node, have dropped below their turn-off thresholds.

From these it drives a high-side gate and a low-side gate. It never lets both gates be on together.

Dead time is adaptive. The incoming gate is released only after the feedback comparator reports that the outgoing gate is below its threshold, plus a short fixed settle delay. A PWM command that stays at mid-level for the hold-off interval shuts both gates off. This supports phase shedding. Leaving that state goes straight to the commanded gate.

Diode emulation blanks the low-side gate for the rest of a switching cycle once the inductor current reverses. The blanking is honoured only after a minimum on time. A minimum off time for the high-side gate is also enforced. All timing values are given in nanoseconds and converted to clock cycles from a clock-frequency parameter. Every input passes through a two-flop synchronizer before use.

Top module: `gate_drive_seq`

## Requirements
- R1: While supplyOk is 0 or disableN is 0, both gateHi and gateLo are 0 no later than 4 clock cycles after the condition reaches the pins, whatever pwmLvl is.
- R2: When the stage is enabled and pwmLvl is steady, gateHi is 1 and gateLo is 0 for pwmLvl = 2'b01 (high). gateHi is 0 and gateLo is 1 for pwmLvl = 2'b00 (low). Any pwmLvl with bit 1 set means mid-level.
- R3: A mid-level run on pwmLvl shorter than the hold-off time (HOLD_NS) leaves the gates unchanged. A mid-level run held for the hold-off time turns both gates off. With the defaults (100 MHz, 150 ns), the gates are still on 17 cycles after the pin change and off after 18 cycles.
- R4: On leaving the three-state shutdown, a move to high turns on only gateHi and a move to low turns on only gateLo. The other gate never pulses in between.
- R5: On a rising PWM, gateLo turns off first. gateHi stays 0 for as long as lsBelow is 0. gateHi rises exactly DEAD cycles + 3 cycles after lsBelow goes to 1 (2 for synchronization, 1 for the state register).
- R6: On a falling PWM, gateHi turns off first. gateLo stays 0 for as long as hsBelow is 0. gateLo rises exactly DEAD cycles + 3 cycles after hsBelow goes to 1.
- R7: With skipN = 0 and PWM low, gateLo stays on while curNeg is 0. Once curNeg is 1, gateLo is forced off and stays off for the rest of that low phase. With skipN = 1, gateLo ignores curNeg.
- R8: In diode-emulation mode, once gateLo turns on it stays on for at least MINON_NS worth of cycles (35 by default) before a current reversal can turn it off.
- R9: After gateHi turns off, it cannot turn on again for at least MINOFF_NS worth of cycles (7 by default), even if PWM returns high at once.
- R10: When the stage becomes enabled, both gates stay 0 while pwmLvl is mid-level. The first valid high or low level then turns on the matching gate.
- R11: gateHi and gateLo are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwmLvl | input | 2 | Decoded PWM command: 00 low, 01 high, 1x mid-level |
| disableN | input | 1 | Active-low stage disable; 0 (or undriven, pulled to 0 outside) turns both gates off |
| supplyOk | input | 1 | Supply-good flag; 0 turns both gates off |
| skipN | input | 1 | Active-low diode-emulation enable |
| curNeg | input | 1 | Inductor current has reversed (negative) |
| lsBelow | input | 1 | Low-side gate voltage is below its turn-off threshold |
| hsBelow | input | 1 | High-side gate-to-switch-node voltage is below its turn-off threshold |
| gateHi | output | 1 | High-side gate command |
| gateLo | output | 1 | Low-side gate command |

## Verification
The bench drives the gate feedback comparators by hand and holds each one off for several cycles. A design with a fixed dead time instead of an adaptive one would then switch the incoming gate on while the outgoing gate is still reported high. The bench also measures the exact dead-time count and the hold-off edge to the cycle. A mid-level window counted off by one, or a short mid-level excursion that wrongly shuts the stage down, would show up in those measurements.

Several further cases are covered. The bench returns PWM high right after a high-side turn-off to catch a missing minimum off time. It asserts current reversal before the low side turns on to catch a missing minimum on time in diode emulation. It also releases the disable input while PWM is mid-level, to catch a sequencer that drives a gate before it sees a valid level.

// File: rtl/gds_pkg.sv
package gds_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_MID  = 2'b10
  } pwm_lvl_e;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_LS_ON   = 3'd1,
    ST_DEAD_HS = 3'd2,
    ST_HS_ON   = 3'd3,
    ST_DEAD_LS = 3'd4,
    ST_TRI_OFF = 3'd5
  } gds_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic holdClr;
    logic holdRun;
    logic deadClr;
    logic deadRun;
    logic onClr;
    logic onRun;
    logic offClr;
    logic offRun;
  } gds_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic holdDone;
    logic deadDone;
    logic onDone;
    logic offDone;
  } gds_done_t;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic pwm_lvl_e decodeLvl(input logic [1:0] raw);
    if (raw[1])       return LVL_MID;
    else if (raw[0])  return LVL_HIGH;
    else              return LVL_LOW;
  endfunction

endpackage

// File: rtl/gds_sync.sv
module gds_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gds_cnt.sv
module gds_cnt #(
  parameter int unsigned LIMIT     = 4,
  parameter bit          START_FULL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= START_FULL ? LIM_V : '0;
    else if (clr)                   cnt <= '0;
    else if (run && (cnt != LIM_V)) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM_V);

  no_overrun_chk: assert property (@(posedge clk) disable iff (!rstN) cnt <= LIM_V)
    else $error("counter beyond limit");
endmodule

// File: rtl/gds_timers.sv
module gds_timers
  import gds_pkg::*;
#(
  parameter int unsigned HOLD_CY  = 15,
  parameter int unsigned DEAD_CY  = 2,
  parameter int unsigned MINON_CY = 35,
  parameter int unsigned MINOFF_CY = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  gds_strobe_t strobe,
  output gds_done_t   done
);
  gds_cnt #(.LIMIT(HOLD_CY), .START_FULL(1'b0)) holdCnt (
    .clk(clk), .rstN(rstN), .clr(strobe.holdClr), .run(strobe.holdRun), .done(done.holdDone));

  gds_cnt #(.LIMIT(DEAD_CY), .START_FULL(1'b0)) deadCnt (
    .clk(clk), .rstN(rstN), .clr(strobe.deadClr), .run(strobe.deadRun), .done(done.deadDone));

  gds_cnt #(.LIMIT(MINON_CY), .START_FULL(1'b0)) onCnt (
    .clk(clk), .rstN(rstN), .clr(strobe.onClr), .run(strobe.onRun), .done(done.onDone));

  // minimum off time starts satisfied after reset
  gds_cnt #(.LIMIT(MINOFF_CY), .START_FULL(1'b1)) offCnt (
    .clk(clk), .rstN(rstN), .clr(strobe.offClr), .run(strobe.offRun), .done(done.offDone));
endmodule

// File: rtl/gds_ctrl.sv
module gds_ctrl
  import gds_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pwm_lvl_e    lvl,
  input  logic        en,
  input  logic        skipEn,
  input  logic        curNeg,
  input  logic        lsBelow,
  input  logic        hsBelow,
  input  gds_done_t   done,
  output gds_strobe_t strobe,
  output logic        gateHi,
  output logic        gateLo
);
  gds_state_e state, stNext;
  logic blank, blankNext;
  logic tripHold;

  assign tripHold = (lvl == LVL_MID) && done.holdDone;

  always_comb begin
    stNext = state;
    if (!en) begin
      stNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF, ST_TRI_OFF: begin
          if (lvl == LVL_LOW)                        stNext = ST_LS_ON;
          else if (lvl == LVL_HIGH && done.offDone)  stNext = ST_HS_ON;
        end
        ST_LS_ON: begin
          if (tripHold)                              stNext = ST_TRI_OFF;
          else if (lvl == LVL_HIGH && done.offDone)  stNext = ST_DEAD_HS;
        end
        ST_DEAD_HS: begin
          if (tripHold)                              stNext = ST_TRI_OFF;
          else if (lvl == LVL_LOW)                   stNext = ST_LS_ON;
          else if (lvl == LVL_HIGH && done.deadDone) stNext = ST_HS_ON;
        end
        ST_HS_ON: begin
          if (tripHold)                              stNext = ST_TRI_OFF;
          else if (lvl == LVL_LOW)                   stNext = ST_DEAD_LS;
        end
        ST_DEAD_LS: begin
          if (tripHold)                              stNext = ST_TRI_OFF;
          else if (lvl == LVL_HIGH && done.offDone)  stNext = ST_HS_ON;
          else if (lvl == LVL_LOW && done.deadDone)  stNext = ST_LS_ON;
        end
        default: stNext = ST_OFF;
      endcase
    end
  end

  // per-cycle low-side blanking for diode emulation
  always_comb begin
    blankNext = 1'b0;
    if (stNext == ST_LS_ON && state == ST_LS_ON)
      blankNext = blank || (skipEn && curNeg && done.onDone);
  end

  always_comb begin
    strobe.holdClr = (lvl != LVL_MID);
    strobe.holdRun = (lvl == LVL_MID);
    strobe.deadClr = !(state == ST_DEAD_HS || state == ST_DEAD_LS);
    strobe.deadRun = (state == ST_DEAD_HS) ? lsBelow : hsBelow;
    strobe.onClr   = (state != ST_LS_ON);
    strobe.onRun   = (state == ST_LS_ON);
    strobe.offClr  = (state == ST_HS_ON) && (stNext != ST_HS_ON);
    strobe.offRun  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      blank  <= 1'b0;
      gateHi <= 1'b0;
      gateLo <= 1'b0;
    end else begin
      state  <= stNext;
      blank  <= blankNext;
      gateHi <= (stNext == ST_HS_ON);
      gateLo <= (stNext == ST_LS_ON) && !(blankNext && skipEn);
    end
  end

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN) !(gateHi && gateLo))
    else $error("both gates on");

  // R1
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!gateHi && !gateLo))
    else $error("gate on while disabled");

  // R5
  hs_waits_ls_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateHi) && $past(state) == ST_DEAD_HS) |-> $past(lsBelow))
    else $error("high side on before low side fell");

  // R6
  ls_waits_hs_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateLo) && $past(state) == ST_DEAD_LS) |-> $past(hsBelow))
    else $error("low side on before high side fell");

  // R3
  tri_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRI_OFF && $past(state) != ST_TRI_OFF) |-> ($past(lvl) == LVL_MID && $past(done.holdDone)))
    else $error("three-state entered without full hold-off");

  // R8
  min_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateLo) && state == ST_LS_ON) |-> $past(done.onDone))
    else $error("low side blanked before minimum on time");
endmodule

// File: rtl/gate_drive_seq.sv
module gate_drive_seq
  import gds_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned HOLD_NS   = 150,
  parameter int unsigned DEAD_NS   = 20,
  parameter int unsigned MINON_NS  = 350,
  parameter int unsigned MINOFF_NS = 70
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwmLvl,
  input  logic       disableN,
  input  logic       supplyOk,
  input  logic       skipN,
  input  logic       curNeg,
  input  logic       lsBelow,
  input  logic       hsBelow,
  output logic       gateHi,
  output logic       gateLo
);
  localparam int unsigned HOLD_CY   = ns2cyc(HOLD_NS, CLK_MHZ);
  localparam int unsigned DEAD_CY   = ns2cyc(DEAD_NS, CLK_MHZ);
  localparam int unsigned MINON_CY  = ns2cyc(MINON_NS, CLK_MHZ);
  localparam int unsigned MINOFF_CY = ns2cyc(MINOFF_NS, CLK_MHZ);
  localparam int unsigned NIN = 8;

  logic [NIN-1:0] rawIn, syncIn;
  gds_strobe_t strobe;
  gds_done_t   done;

  assign rawIn = {pwmLvl, disableN, supplyOk, skipN, curNeg, lsBelow, hsBelow};

  gds_sync #(.WIDTH(NIN), .STAGES(2)) inSync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncIn));

  gds_ctrl ctrl (
    .clk(clk), .rstN(rstN),
    .lvl(decodeLvl(syncIn[7:6])),
    .en(syncIn[5] && syncIn[4]),
    .skipEn(!syncIn[3]),
    .curNeg(syncIn[2]),
    .lsBelow(syncIn[1]),
    .hsBelow(syncIn[0]),
    .done(done),
    .strobe(strobe),
    .gateHi(gateHi),
    .gateLo(gateLo));

  gds_timers #(
    .HOLD_CY(HOLD_CY), .DEAD_CY(DEAD_CY), .MINON_CY(MINON_CY), .MINOFF_CY(MINOFF_CY)
  ) timers (
    .clk(clk), .rstN(rstN), .strobe(strobe), .done(done));
endmodule

// File: tb/gate_drive_seq_test.sv
module gate_drive_seq_test;
  localparam int MHZ       = 100;
  localparam int HOLD_CY   = (150 * MHZ + 999) / 1000;
  localparam int DEAD_CY   = (20 * MHZ + 999) / 1000;
  localparam int MINON_CY  = (350 * MHZ + 999) / 1000;
  localparam int MINOFF_CY = (70 * MHZ + 999) / 1000;
  localparam logic [1:0] P_LOW = 2'b00, P_HIGH = 2'b01, P_MID = 2'b10;

  logic clk = 1'b0;
  logic rstN, disableN, supplyOk, skipN, curNeg;
  logic [1:0] pwmLvl;
  logic autoFb, lsMan, hsMan, lsAuto, hsAuto;
  logic gateHi, gateLo;
  logic lsBelow, hsBelow;
  int checks = 0, errors = 0, overlaps = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign lsBelow = autoFb ? lsAuto : lsMan;
  assign hsBelow = autoFb ? hsAuto : hsMan;

  gate_drive_seq uut (
    .clk(clk), .rstN(rstN), .pwmLvl(pwmLvl), .disableN(disableN), .supplyOk(supplyOk),
    .skipN(skipN), .curNeg(curNeg), .lsBelow(lsBelow), .hsBelow(hsBelow),
    .gateHi(gateHi), .gateLo(gateLo));

  always @(negedge clk) begin
    lsAuto <= !gateLo;
    hsAuto <= !gateHi;
    if (gateHi && gateLo) overlaps++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gates(input string req, input int hi, input int lo);
    check(gateHi == hi[0] && gateLo == lo[0], req, {gateHi, gateLo}, {hi[0], lo[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k, bad, len;
    rstN = 0; pwmLvl = P_MID; disableN = 0; supplyOk = 0; skipN = 1; curNeg = 0;
    autoFb = 1; lsMan = 1; hsMan = 1; lsAuto = 1; hsAuto = 1;
    cyc(5);
    gates("R1 reset", 0, 0);
    rstN = 1;
    cyc(2);
    pwmLvl = P_HIGH; cyc(6);
    gates("R1 both off", 0, 0);
    supplyOk = 1; cyc(6);
    gates("R1 disableN low", 0, 0);
    supplyOk = 0; disableN = 1; cyc(6);
    gates("R1 supply low", 0, 0);

    // R10: enable while mid-level
    pwmLvl = P_MID; supplyOk = 1; cyc(10);
    gates("R10 wait for level", 0, 0);
    pwmLvl = P_LOW; cyc(5);
    gates("R10 first low", 0, 1);
    gates("R2 low steady", 0, 1);

    // R5: adaptive dead time on rising PWM
    autoFb = 0; lsMan = 0; hsMan = 1;
    pwmLvl = P_HIGH;
    k = 0; while (gateLo && k < 20) begin @(negedge clk); k++; end
    check(!gateLo, "R5 ls off first", gateLo, 0);
    bad = 0;
    repeat (6) begin @(negedge clk); if (gateHi) bad++; end
    check(bad == 0, "R5 hs held by feedback", bad, 0);
    lsMan = 1;
    k = 0; do begin @(negedge clk); k++; end while (!gateHi && k < 30);
    check(k == DEAD_CY + 3, "R5 dead count", k, DEAD_CY + 3);
    hsMan = 0; cyc(5);
    gates("R2 high steady", 1, 0);

    // R6: adaptive dead time on falling PWM
    pwmLvl = P_LOW;
    k = 0; while (gateHi && k < 20) begin @(negedge clk); k++; end
    bad = 0;
    repeat (4) begin @(negedge clk); if (gateLo) bad++; end
    check(bad == 0, "R6 ls held by feedback", bad, 0);
    hsMan = 1;
    k = 0; do begin @(negedge clk); k++; end while (!gateLo && k < 30);
    check(k == DEAD_CY + 3, "R6 dead count", k, DEAD_CY + 3);
    lsMan = 0; cyc(5);
    gates("R6 ls steady", 0, 1);
    autoFb = 1;

    // R3: short and full mid-level excursions
    pwmLvl = P_HIGH; cyc(10);
    pwmLvl = P_MID;
    bad = 0;
    repeat (HOLD_CY - 3) begin @(negedge clk); if (!gateHi) bad++; end
    pwmLvl = P_HIGH;
    repeat (10) begin @(negedge clk); if (!gateHi) bad++; end
    check(bad == 0, "R3 short excursion ignored", bad, 0);
    pwmLvl = P_MID;
    cyc(HOLD_CY + 2);
    gates("R3 still on before hold-off", 1, 0);
    cyc(1);
    gates("R3 off at hold-off", 0, 0);
    cyc(5);

    // R4: exit three-state
    pwmLvl = P_HIGH; bad = 0;
    repeat (8) begin @(negedge clk); if (gateLo) bad++; end
    check(bad == 0 && gateHi, "R4 exit to high", bad, 0);
    pwmLvl = P_MID; cyc(HOLD_CY + 10);
    gates("R3 tri again", 0, 0);
    pwmLvl = P_LOW; bad = 0;
    repeat (8) begin @(negedge clk); if (gateHi) bad++; end
    check(bad == 0 && gateLo, "R4 exit to low", bad, 0);

    // R9: minimum off time
    pwmLvl = P_HIGH; cyc(10);
    pwmLvl = P_LOW;
    k = 0; while (gateHi && k < 20) begin @(negedge clk); k++; end
    pwmLvl = P_HIGH;
    k = 1; while (!gateHi && k < 40) begin @(negedge clk); if (!gateHi) k++; end
    check(k >= MINOFF_CY, "R9 min off", k, MINOFF_CY);
    cyc(5);

    // R8 and R7: diode emulation with current already reversed
    skipN = 0; curNeg = 1; cyc(4);
    pwmLvl = P_LOW;
    k = 0; while (!gateLo && k < 30) begin @(negedge clk); k++; end
    len = 1;
    while (gateLo && len < 100) begin @(negedge clk); if (gateLo) len++; end
    check(len >= MINON_CY && len <= MINON_CY + 2, "R8 min on", len, MINON_CY + 1);
    bad = 0;
    repeat (20) begin @(negedge clk); if (gateLo || gateHi) bad++; end
    check(bad == 0, "R7 blanked rest of phase", bad, 0);

    // R7: positive current keeps low side on, reversal turns it off
    pwmLvl = P_HIGH; cyc(10);
    curNeg = 0; pwmLvl = P_LOW; cyc(60);
    gates("R7 positive current", 0, 1);
    curNeg = 1; cyc(4);
    gates("R7 reversal", 0, 0);

    // R7: synchronous mode ignores curNeg
    skipN = 1;
    pwmLvl = P_HIGH; cyc(10);
    pwmLvl = P_LOW; cyc(60);
    gates("R7 sync mode ignores curNeg", 0, 1);

    // R1 mid-operation, then R10 restart
    disableN = 0; cyc(4);
    gates("R1 disable in operation", 0, 0);
    pwmLvl = P_MID; disableN = 1; cyc(10);
    gates("R10 restart at mid", 0, 0);
    pwmLvl = P_HIGH; cyc(6);
    gates("R10 restart high", 1, 0);
    supplyOk = 0; cyc(4);
    gates("R1 supply drop", 0, 0);

    check(overlaps == 0, "R11 no overlap", overlaps, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule